// File: doc/BRIEF.md
# Serial Register Port with Chained Command Frames

This block is the slave side of a three-wire serial link made of a chip-enable line, a shift clock and one data line. It exposes a bank of small registers, sixteen 4-bit registers with the default width. The chip-enable, the shift clock and the incoming data are brought into the system clock domain through two-stage synchronisers. Each shift clock edge is detected there, so the whole block runs on the system clock.

Each transfer is a frame of eight shift clock pulses. A frame carries four control bits and then a payload as wide as a register. The control bits select one of four actions: load the address register, write the addressed register, read the addressed register back on the data line, or terminate. While chip-enable stays high, frames follow each other without a gap. An address frame, one or more data frames and a read frame can therefore share one chip-enable window.

The data line is split into an input, an output and an output enable, which the pad ring joins into one bidirectional pin. The output enable is high only while read data is being driven.

Top module: `ser3w_regport`

## Requirements
- R1: After reset every register and the address register hold zero, and `sio_oe` is low.
- R2: A frame is eight rising edges of `sclk` with `ce` high. `sio_i` is sampled on each rising edge, most significant bit first. Bit 1 is ignored. Bits 2, 3 and 4 form the command {RW, AD, DT}. Bits 5 to 8 are the payload.
- R3: Command {RW,AD,DT} = 3'b010 loads the payload into the address register at the eighth rising edge.
- R4: Command 3'b001 writes the payload into the register selected by the address register. The write happens only once the eighth bit has been captured.
- R5: Command 3'b101 reads the addressed register. On the falling edges of pulses 4 to 7 the block drives its bits on `sio_o`, D3 first, with `sio_oe` high. `sio_oe` returns low on the falling edge of pulse 8.
- R6: Command 3'b000 terminates once the fourth bit is received. Every later pulse is ignored until `ce` goes low.
- R7: Commands 3'b011, 3'b100, 3'b110 and 3'b111 change neither the registers nor the address.
- R8: While `ce` is low, the bit position and the terminated state are cleared. A frame cut short by `ce` falling writes nothing.
- R9: Frames chain back to back while `ce` stays high, and a write sequence may be followed by a read frame in the same window.
- R10: `sio_oe` stays low outside the read data bits of a read frame, and so stays low during write and address frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable, high during a transaction |
| sclk | input | 1 | Shift clock from the master |
| sio_i | input | 1 | Serial data from the pad |
| sio_o | output | 1 | Serial read data to the pad |
| sio_oe | output | 1 | Output enable for the data pad |

## Verification
The bench builds the block with the default 4-bit payload, which gives sixteen registers. It writes and reads back every address, so each position of the address register is decoded at least once. The shift clock is slow against the system clock, at eight system cycles per phase. This leaves room for the synchroniser delay and lets the model predict the data line at each rising shift edge. Chained frames, termination, the unused command codes and a frame aborted after six bits are all checked through later read frames.

// File: rtl/ser3w_regport.sv
module ser3w_regport #(
  parameter int DW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  input  logic sio_i,
  output logic sio_o,
  output logic sio_oe
);
  localparam int CTRL_W = 4;
  localparam int FRAME  = CTRL_W + DW;
  localparam int CNT_W  = $clog2(FRAME);
  localparam int NREG   = 1 << DW;
  localparam int RDC_W  = $clog2(DW + 1);
  localparam logic [2:0] OP_END  = 3'b000;
  localparam logic [2:0] OP_WR   = 3'b001;
  localparam logic [2:0] OP_ADDR = 3'b010;
  localparam logic [2:0] OP_RD   = 3'b101;

  logic [1:0] ce_sy, io_sy;
  logic [2:0] ck_sy;
  logic [CNT_W-1:0] cnt;
  logic [FRAME-2:0] shreg;
  logic [2:0] op;
  logic term;
  logic [DW-1:0] addr;
  logic [DW-1:0] bank [NREG];
  logic [RDC_W-1:0] rd_left;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_sy <= '0;
      io_sy <= '0;
      ck_sy <= '0;
    end else begin
      ce_sy <= {ce_sy[0], ce};
      io_sy <= {io_sy[0], sio_i};
      ck_sy <= {ck_sy[1:0], sclk};
    end

  wire ce_s  = ce_sy[1];
  wire sio_s = io_sy[1];
  wire rise  = ck_sy[1] & ~ck_sy[2];
  wire fall  = ~ck_sy[1] & ck_sy[2];

  wire shift      = ce_s && !term && rise;
  wire ctrl_done  = shift && (cnt == CNT_W'(CTRL_W - 1));
  wire frame_done = shift && (cnt == CNT_W'(FRAME - 1));
  wire [2:0]    op_now  = {shreg[1:0], sio_s};
  wire [DW-1:0] payload = {shreg[DW-2:0], sio_s};
  wire wr_en = frame_done && (op == OP_WR);
  wire ad_en = frame_done && (op == OP_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
      op    <= OP_END;
      term  <= 1'b0;
    end else if (!ce_s) begin
      cnt  <= '0;
      op   <= OP_END;
      term <= 1'b0;
    end else if (shift) begin
      shreg <= {shreg[FRAME-3:0], sio_s};
      cnt   <= (cnt == CNT_W'(FRAME - 1)) ? '0 : cnt + 1'b1;
      if (ctrl_done) begin
        op <= op_now;
        if (op_now == OP_END) term <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr <= '0;
    else if (ad_en) addr <= payload;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[addr] <= payload;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_left <= '0;
      sio_oe  <= 1'b0;
      sio_o   <= 1'b0;
    end else if (!ce_s) begin
      rd_left <= '0;
      sio_oe  <= 1'b0;
    end else begin
      if (ctrl_done && op_now == OP_RD) rd_left <= RDC_W'(DW);
      if (fall) begin
        if (rd_left != '0) begin
          sio_oe  <= 1'b1;
          sio_o   <= bank[addr][rd_left - 1'b1];
          rd_left <= rd_left - 1'b1;
        end else begin
          sio_oe <= 1'b0;
        end
      end
    end
endmodule

module ser3w_regport_chk #(
  parameter int DW = 4,
  parameter int CNT_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ce_s,
  input logic rise,
  input logic fall,
  input logic term,
  input logic wr_en,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0] op,
  input logic [DW-1:0] addr,
  input logic sio_oe
);
  assert_ce_low_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (cnt == '0) && !term);
  assert_no_write_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> !wr_en);
  assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sio_oe) |-> $past(fall));
  assert_oe_only_in_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe |-> (op == 3'b101) && ce_s);
  assert_addr_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> $past(rise) && $past(op) == 3'b010);
endmodule

bind ser3w_regport ser3w_regport_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .rise(rise), .fall(fall),
  .term(term), .wr_en(wr_en), .cnt(cnt), .op(op), .addr(addr), .sio_oe(sio_oe)
);

// File: tb/ser3w_regport_tb.sv
module ser3w_regport_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic sclk = 1'b0;
  logic sio_i = 1'b0;
  logic sio_o, sio_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] mem [16];
  logic [3:0] m_addr;
  bit m_term;

  always #5 clk = ~clk;

  ser3w_regport #(.DW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk),
    .sio_i(sio_i), .sio_o(sio_o), .sio_oe(sio_oe)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic b, input bit exp_oe, input logic exp_bit, input string req);
    @(negedge clk) sio_i = b;
    repeat (HALF) @(negedge clk);
    chk({req, " oe"}, {3'b0, sio_oe}, {3'b0, exp_oe});
    if (exp_oe) chk({req, " bit"}, {3'b0, sio_o}, {3'b0, exp_bit});
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic b0, input logic [2:0] c, input logic [3:0] p,
                       input string req, input int nbits = 8);
    logic [7:0] bits = {b0, c, p};
    bit rd = !m_term && c == 3'b101;
    for (int i = 0; i < nbits; i++)
      pulse(bits[7-i], rd && i >= 4, (i >= 4) ? mem[m_addr][7-i] : 1'b0, req);
    if (!m_term && nbits == 8) begin
      case (c)
        3'b000: m_term = 1;
        3'b010: m_addr = p;
        3'b001: mem[m_addr] = p;
        default: ;
      endcase
    end
  endtask

  task automatic ce_on();
    @(negedge clk) ce = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ce_off();
    @(negedge clk) ce = 1'b0;
    repeat (6) @(negedge clk);
    m_term = 0;
    chk("R10 idle", {3'b0, sio_oe}, 4'h0);
  endtask

  task automatic readback(input string req);
    ce_on();
    for (int a = 0; a < 16; a++) begin
      frame(1'b0, 3'b010, 4'(a), req);
      frame(1'b0, 3'b101, 4'h0, req);
    end
    ce_off();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 4'h0;
    m_addr = 4'h0;
    m_term = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset oe", {3'b0, sio_oe}, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_on();
    frame(1'b0, 3'b101, 4'h0, "R1 addr0");
    ce_off();
    readback("R1");

    ce_on();
    for (int a = 0; a < 16; a++) begin
      frame(a[0], 3'b010, 4'(a), "R3");
      frame(~a[0], 3'b001, 4'(15 - a) ^ 4'h5, "R4 R2");
    end
    ce_off();
    readback("R4");

    ce_on();
    frame(1'b1, 3'b010, 4'h9, "R9");
    frame(1'b0, 3'b001, 4'h3, "R9");
    frame(1'b1, 3'b001, 4'hC, "R9");
    frame(1'b0, 3'b101, 4'h0, "R9 R5");
    frame(1'b0, 3'b001, 4'hA, "R9");
    frame(1'b0, 3'b101, 4'h0, "R9 R5");
    ce_off();

    ce_on();
    frame(1'b0, 3'b010, 4'h2, "R6");
    frame(1'b1, 3'b000, 4'hF, "R6");
    frame(1'b0, 3'b001, 4'h7, "R6");
    frame(1'b0, 3'b010, 4'h8, "R6");
    frame(1'b0, 3'b101, 4'h0, "R6");
    ce_off();
    ce_on();
    frame(1'b0, 3'b101, 4'h0, "R6 R8");
    ce_off();

    ce_on();
    frame(1'b0, 3'b011, 4'h1, "R7");
    frame(1'b0, 3'b100, 4'h4, "R7");
    frame(1'b0, 3'b110, 4'hE, "R7");
    frame(1'b0, 3'b111, 4'hB, "R7");
    frame(1'b0, 3'b101, 4'h0, "R7");
    ce_off();

    ce_on();
    frame(1'b0, 3'b010, 4'h5, "R8");
    frame(1'b0, 3'b001, 4'h0, "R8 cut", 6);
    ce_off();
    ce_on();
    frame(1'b0, 3'b101, 4'h0, "R8");
    frame(1'b0, 3'b001, 4'h6, "R8");
    frame(1'b0, 3'b101, 4'h0, "R8");
    ce_off();

    readback("R7 R8 final");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule